// File: doc/BRIEF.md
# Bidirectional Stepper Phase Sequencer

This block produces the contact drive pattern for a small stepper motor. It advances on a step tick, a one-cycle enable qualified against the system clock. It holds three phase flip-flops. Phase A inverts itself on every step. Phases B and C each load through a two-way selector whose select line is the rotation direction. Phase B is brought out on two contact pins, so the three flip-flops drive four contacts.

The rotation direction comes from a mode selector, which picks one of two sources:

- **Static mode:** an external direction level is used as it is.
- **Swing mode:** the output of an 8-bit step-counting timer is used. This output flips each time the count reaches a programmed period, so the motor swings back and forth. The number of steps in each direction grows linearly with the period value.

Top module: `stepper_phase_seq`

## Requirements
- R1: A synchronous active-high reset clears phases A, B and C, the step counter and the timer output to 0. After reset, dir_now reads 0 when mode_swing is 1.
- R2: In a cycle with step_tick low, the phases, the step counter and the timer output all keep their values.
- R3: On every step tick, phase A takes the inverse of its previous value.
- R4: On a step tick, phase B loads phase A when the direction is 0 and phase C when the direction is 1. Both values are the ones held before the tick.
- R5: On a step tick, phase C loads phase A when the direction is 0 and phase B when the direction is 1. Both values are the ones held before the tick.
- R6: The direction is dir_level when mode_swing is 0 and the timer output when mode_swing is 1. It is visible on dir_now in the same cycle.
- R7: On a step tick where the counter equals period, the timer output inverts and the counter reloads to 0. On any other tick the counter increments by one. The timer output therefore flips once every period+1 ticks.
- R8: With period 0, the timer output inverts on every step tick. With period 255, it inverts once every 256 ticks.
- R9: coil_b1 and coil_b2 both carry phase B and are always equal.
- R10: While mode_swing is 1, changes on dir_level have no effect on dir_now or on the phases.
- R11: If period is lowered below the current count, the counter keeps incrementing. It wraps from 255 to 0 without a toggle and flips the timer output only on reaching the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_tick | input | 1 | One-cycle step enable |
| mode_swing | input | 1 | 1 selects the timer as direction source, 0 selects dir_level |
| dir_level | input | 1 | External static direction |
| period | input | 8 | Step-timer period value |
| coil_a | output | 1 | Phase A contact |
| coil_b1 | output | 1 | Phase B, first contact |
| coil_b2 | output | 1 | Phase B, second contact |
| coil_c | output | 1 | Phase C, contact |
| dir_now | output | 1 | Direction currently in effect |

## Verification
The embedded assertions check on every cycle that idle cycles change nothing, that phase A inverts on each step, and that B and C load the inputs their selectors name. They also check that the step counter either increments or reloads exactly at the period match. Only the bench scenarios can show the end-to-end behaviour:

- the swing period measured in ticks at the period extremes;
- the wrap-around after the period is lowered mid-count;
- the way dir_level has no effect in swing mode;
- the full phase sequence in each direction against an independent model.

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_tick,
  input  logic             mode_swing,
  input  logic             dir_level,
  input  logic [CNT_W-1:0] period,
  output logic             coil_a,
  output logic             coil_b1,
  output logic             coil_b2,
  output logic             coil_c,
  output logic             dir_now
);

  logic             ph_a, ph_b, ph_c;
  logic             swing_q;
  logic [CNT_W-1:0] step_cnt;
  logic             hit;

  assign hit     = (step_cnt == period);
  assign dir_now = (mode_swing & swing_q) | (~mode_swing & dir_level);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_cnt <= '0;
      swing_q  <= 1'b0;
    end else if (step_tick) begin
      if (hit) begin
        step_cnt <= '0;
        swing_q  <= ~swing_q;
      end else begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_a <= 1'b0;
      ph_b <= 1'b0;
      ph_c <= 1'b0;
    end else if (step_tick) begin
      ph_a <= ~ph_a;
      ph_b <= (ph_a & ~dir_now) | (ph_c & dir_now);
      ph_c <= (ph_a & ~dir_now) | (ph_b & dir_now);
    end
  end

  assign coil_a  = ph_a;
  assign coil_b1 = ph_b;
  assign coil_b2 = ph_b;
  assign coil_c  = ph_c;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable({ph_a, ph_b, ph_c, swing_q, step_cnt}));

  assert_a_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    step_tick |=> (ph_a != $past(ph_a)));

  assert_b_source_R4: assert property (@(posedge clk) disable iff (rst)
    step_tick |=> (ph_b == ($past(dir_now) ? $past(ph_c) : $past(ph_a))));

  assert_c_source_R5: assert property (@(posedge clk) disable iff (rst)
    step_tick |=> (ph_c == ($past(dir_now) ? $past(ph_b) : $past(ph_a))));

  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (rst)
    (step_tick && !hit) |=> (step_cnt == $past(step_cnt) + 1'b1) && $stable(swing_q));

  assert_cnt_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (step_tick && hit) |=> (step_cnt == '0) && (swing_q != $past(swing_q)));

endmodule

// File: tb/stepper_phase_seq_tb.sv
module stepper_phase_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic       step_tick = 0;
  logic       mode_swing = 0;
  logic       dir_level = 0;
  logic [7:0] period = 8'd3;
  logic       coil_a, coil_b1, coil_b2, coil_c, dir_now;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  int m_a = 0, m_b = 0, m_c = 0, m_sw = 0, m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepper_phase_seq u_dut (
    .clk(clk), .rst(rst), .step_tick(step_tick), .mode_swing(mode_swing),
    .dir_level(dir_level), .period(period), .coil_a(coil_a), .coil_b1(coil_b1),
    .coil_b2(coil_b2), .coil_c(coil_c), .dir_now(dir_now)
  );

  function automatic int m_dir();
    return mode_swing ? m_sw : int'(dir_level);
  endfunction

  always @(posedge clk) begin
    int d, na, nb, nc;
    if (rst) begin
      m_a = 0; m_b = 0; m_c = 0; m_sw = 0; m_cnt = 0;
    end else if (step_tick) begin
      d  = m_dir();
      na = 1 - m_a;
      nb = d ? m_c : m_a;
      nc = d ? m_b : m_a;
      m_a = na; m_b = nb; m_c = nc;
      if (m_cnt == int'(period)) begin
        m_cnt = 0;
        m_sw = 1 - m_sw;
      end else begin
        m_cnt = (m_cnt + 1) % 256;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R3 coil_a", int'(coil_a), m_a);
      check("R4 coil_b1", int'(coil_b1), m_b);
      check("R5 coil_c", int'(coil_c), m_c);
      check("R6 dir_now", int'(dir_now), m_dir());
      check("R9 coil_b2", int'(coil_b2), int'(coil_b1));
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); step_tick = 1;
      @(negedge clk); step_tick = 0;
    end
  endtask

  int flips;
  int last;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    mode_swing = 1;
    #1;
    check("R1 reset coil_a", int'(coil_a), 0);
    check("R1 reset coil_b1", int'(coil_b1), 0);
    check("R1 reset coil_c", int'(coil_c), 0);
    check("R1 reset dir_now", int'(dir_now), 0);
    mode_swing = 0;

    dir_level = 0; ticks(6);
    dir_level = 1; ticks(7);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      step_tick = (i % 3 != 1);
      dir_level = (i % 5 < 2);
    end
    @(negedge clk); step_tick = 0;

    begin
      int a0, b0, c0;
      a0 = coil_a; b0 = coil_b1; c0 = coil_c;
      repeat (5) @(negedge clk);
      check("R2 idle hold a", int'(coil_a), a0);
      check("R2 idle hold b", int'(coil_b1), b0);
      check("R2 idle hold c", int'(coil_c), c0);
    end

    mode_swing = 1; period = 8'd3;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); step_tick = 1; dir_level = i[0];
      @(negedge clk); step_tick = 0;
    end
    check("R10 dir ignored in swing", int'(dir_now), m_sw);

    rst = 1; @(negedge clk); rst = 0; period = 8'd0;
    flips = 0; last = dir_now;
    for (int i = 0; i < 10; i++) begin
      ticks(1);
      if (int'(dir_now) != last) flips++;
      last = dir_now;
    end
    check("R8 period 0 flips per tick", flips, 10);

    rst = 1; @(negedge clk); rst = 0; period = 8'd255;
    flips = 0; last = dir_now;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); step_tick = 1;
      @(negedge clk); step_tick = 0;
      if (int'(dir_now) != last) begin
        flips++;
        if (flips == 1) check("R8 period 255 first flip tick", i + 1, 256);
        if (flips == 2) check("R7 period 255 second flip tick", i + 1, 512);
      end
      last = dir_now;
    end
    check("R7 flip count", flips, 2);

    rst = 1; @(negedge clk); rst = 0; period = 8'd20;
    ticks(10);
    period = 8'd4;
    flips = 0; last = dir_now;
    for (int i = 0; i < 260; i++) begin
      ticks(1);
      if (int'(dir_now) != last && flips == 0) begin
        check("R11 wrap before match", i + 1, 251);
        flips++;
      end
      last = dir_now;
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule